// File: doc/BRIEF.md
# Slow Clock Calibration Counter

This block measures the frequency of a slow, free-running clock against a fast reference clock. It counts how many reference cycles elapse while a programmed number of slow-clock cycles go by. Software then turns that count into a period or frequency estimate. All logic runs in the reference domain. Each slow source is brought in through its own two-flop synchronizer with rising-edge detection, and a select input picks which source is measured.

A measurement either repeats without pause (cycling mode) or runs once per request (one-off mode). A one-off measurement starts on a 0-to-1 transition of the start input. A reference-cycle timeout guards every measurement. When the selected slow clock is missing or too slow, the timeout ends the measurement, raises a timeout flag and clears the counting state, so the next measurement starts clean. The source select, the cycle limit and the timeout threshold are captured when a measurement begins. Later changes to them wait for the next measurement.

Top module: `slowcal_meter`

## Requirements
- R1: While reset is high, and in the first cycle after it, `ready_o` and `timeout_o` are 0 and `count_o` is 0.
- R2: A completed measurement reports in `count_o` the number of reference cycles from the first synchronized rising edge of the selected source after the measurement begins up to the N-th rising edge after it. For a source of period P reference cycles this is N*P, where N is the captured limit.
- R3: A limit of 0 is treated as a limit of 1, so the result is one slow period.
- R4: `sel_i` is a binary index that picks bit `sel_i` of `slow_clk_i` as the measured source.
- R5: With `cycle_en_i` low, a 0-to-1 transition of `start_i`, seen while the block is idle, begins exactly one measurement. Holding `start_i` high does not begin another.
- R6: `ready_o` and `count_o` keep the last result while the block is idle. A measurement begun from idle clears `ready_o` and `timeout_o` in the cycle after the start transition is sampled.
- R7: While `cycle_en_i` is high, measurements follow one another back to back. Each completion updates `count_o` and leaves `ready_o` high.
- R8: Clearing `cycle_en_i` lets the measurement in progress finish or time out. The block then stays idle, and later slow-clock activity leaves the result unchanged.
- R9: Changes to `sel_i`, `limit_i` and `tmo_thresh_i` during a measurement do not affect it. They are captured at the next begin.
- R10: If a measurement does not complete within T+1 reference cycles of running, where T is the captured threshold, it ends with `timeout_o` = 1, `ready_o` = 0 and `count_o` = 0. Counting the clock edge that samples the start transition as the first, `timeout_o` is first seen high after edge T+2.
- R11: A measurement begun after a timeout produces the same result as one begun from reset.
- R12: `ready_o` and `timeout_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_clk_i | input | NUM_SRC | Slow clock sources, asynchronous to clk |
| sel_i | input | SEL_W | Index of the source to measure |
| limit_i | input | LIMIT_W | Number of slow cycles per measurement (0 means 1) |
| start_i | input | 1 | One-off trigger, acts on a rising transition |
| cycle_en_i | input | 1 | Continuous measurement enable |
| tmo_thresh_i | input | TMO_W | Timeout threshold in reference cycles |
| ready_o | output | 1 | A valid result is held in count_o |
| timeout_o | output | 1 | The last measurement timed out |
| count_o | output | COUNT_W | Measured reference-cycle count |

## Verification
The bench builds the block with four sources, a 3-bit limit and 12-bit count and threshold widths. With a 3-bit limit, every limit value from 0 to 7 can be swept on each of three running sources, whose half-periods of 1, 3 and 5 reference cycles give results that can be computed exactly. The fourth source is held constant, so the timeout path can be driven with several small thresholds and its latency checked to the cycle. Because the widths are small, the result and the threshold also stay well clear of wrap-around.

// File: rtl/slowcal_pkg.sv
`timescale 1ns/1ps
package slowcal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_COUNT = 2'd2
    } cal_state_e;

    // A limit of zero measures a single slow period.
    function automatic logic [31:0] limit_floor1(input logic [31:0] raw);
        return (raw == 32'd0) ? 32'd1 : raw;
    endfunction

endpackage

// File: rtl/slowcal_sync.sv
`timescale 1ns/1ps
module slowcal_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic edge_o
);
    logic ff1_q, ff2_q, ff3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ff1_q <= 1'b0;
            ff2_q <= 1'b0;
            ff3_q <= 1'b0;
        end else begin
            ff1_q <= async_i;
            ff2_q <= ff1_q;
            ff3_q <= ff2_q;
        end
    end

    assign edge_o = ff2_q & ~ff3_q;
endmodule

// File: rtl/slowcal_engine.sv
`timescale 1ns/1ps
module slowcal_engine #(
    parameter int NUM_SRC = 4,
    parameter int LIMIT_W = 8,
    parameter int COUNT_W = 16,
    parameter int TMO_W   = 16,
    localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               cycle_en_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [LIMIT_W-1:0] limit_i,
    input  logic [TMO_W-1:0]   thresh_i,
    input  logic [NUM_SRC-1:0] edges_i,
    output logic               ready_o,
    output logic               timeout_o,
    output logic [COUNT_W-1:0] count_o,
    output logic               idle_o,
    output logic [TMO_W-1:0]   tmo_cnt_o,
    output logic [TMO_W-1:0]   tmo_thr_o
);
    import slowcal_pkg::*;

    typedef struct packed {
        logic [SEL_W-1:0]   sel;
        logic [LIMIT_W-1:0] lim;
        logic [TMO_W-1:0]   thr;
    } cfg_t;

    cal_state_e         state_q;
    cfg_t               cfg_q;
    logic               start_d;
    logic [LIMIT_W-1:0] edge_cnt_q;
    logic [COUNT_W-1:0] ref_q;
    logic [TMO_W-1:0]   tmo_q;
    logic               ready_q, tmo_flag_q;
    logic [COUNT_W-1:0] result_q;

    logic start_rise, begin_idle, running, edge_sel;
    logic done_evt, tmo_evt, finish, reload;

    always_comb begin
        start_rise = start_i & ~start_d;
        running    = (state_q != ST_IDLE);
        begin_idle = (state_q == ST_IDLE) && (start_rise || cycle_en_i);
        edge_sel   = edges_i[cfg_q.sel];
        done_evt   = (state_q == ST_COUNT) && edge_sel &&
                     ((edge_cnt_q + LIMIT_W'(1)) == cfg_q.lim);
        tmo_evt    = running && !done_evt && (tmo_q == cfg_q.thr);
        finish     = done_evt || tmo_evt;
        reload     = begin_idle || (finish && cycle_en_i);
    end

    // Measurement sequencing and counters
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cfg_q      <= '0;
            start_d    <= 1'b0;
            edge_cnt_q <= '0;
            ref_q      <= '0;
            tmo_q      <= '0;
        end else begin
            start_d <= start_i;
            if (reload) begin
                cfg_q.sel  <= sel_i;
                cfg_q.lim  <= LIMIT_W'(limit_floor1(32'(limit_i)));
                cfg_q.thr  <= thresh_i;
                tmo_q      <= '0;
                edge_cnt_q <= '0;
                ref_q      <= '0;
                state_q    <= ST_ARM;
            end else if (finish) begin
                state_q <= ST_IDLE;
            end else if (running) begin
                tmo_q <= tmo_q + TMO_W'(1);
                if (state_q == ST_ARM) begin
                    if (edge_sel) begin
                        state_q    <= ST_COUNT;
                        ref_q      <= '0;
                        edge_cnt_q <= '0;
                    end
                end else begin
                    ref_q <= ref_q + COUNT_W'(1);
                    if (edge_sel) edge_cnt_q <= edge_cnt_q + LIMIT_W'(1);
                end
            end
        end
    end

    // Result and status flags
    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q    <= 1'b0;
            tmo_flag_q <= 1'b0;
            result_q   <= '0;
        end else if (begin_idle) begin
            ready_q    <= 1'b0;
            tmo_flag_q <= 1'b0;
        end else if (done_evt) begin
            ready_q    <= 1'b1;
            tmo_flag_q <= 1'b0;
            result_q   <= ref_q + COUNT_W'(1);
        end else if (tmo_evt) begin
            ready_q    <= 1'b0;
            tmo_flag_q <= 1'b1;
            result_q   <= '0;
        end
    end

    assign ready_o   = ready_q;
    assign timeout_o = tmo_flag_q;
    assign count_o   = result_q;
    assign idle_o    = (state_q == ST_IDLE);
    assign tmo_cnt_o = tmo_q;
    assign tmo_thr_o = cfg_q.thr;
endmodule

// File: rtl/slowcal_meter.sv
`timescale 1ns/1ps
module slowcal_meter #(
    parameter int NUM_SRC = 4,
    parameter int LIMIT_W = 8,
    parameter int COUNT_W = 16,
    parameter int TMO_W   = 16,
    localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] slow_clk_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [LIMIT_W-1:0] limit_i,
    input  logic               start_i,
    input  logic               cycle_en_i,
    input  logic [TMO_W-1:0]   tmo_thresh_i,
    output logic               ready_o,
    output logic               timeout_o,
    output logic [COUNT_W-1:0] count_o
);
    logic [NUM_SRC-1:0] src_edges;
    logic               eng_idle;
    logic [TMO_W-1:0]   eng_tmo_cnt;
    logic [TMO_W-1:0]   eng_tmo_thr;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        slowcal_sync u_sync (
            .clk     (clk),
            .rst     (rst),
            .async_i (slow_clk_i[g]),
            .edge_o  (src_edges[g])
        );
    end

    slowcal_engine #(
        .NUM_SRC (NUM_SRC),
        .LIMIT_W (LIMIT_W),
        .COUNT_W (COUNT_W),
        .TMO_W   (TMO_W)
    ) u_engine (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .cycle_en_i (cycle_en_i),
        .sel_i      (sel_i),
        .limit_i    (limit_i),
        .thresh_i   (tmo_thresh_i),
        .edges_i    (src_edges),
        .ready_o    (ready_o),
        .timeout_o  (timeout_o),
        .count_o    (count_o),
        .idle_o     (eng_idle),
        .tmo_cnt_o  (eng_tmo_cnt),
        .tmo_thr_o  (eng_tmo_thr)
    );
endmodule

// File: rtl/slowcal_meter_chk.sv
`timescale 1ns/1ps
module slowcal_meter_chk #(
    parameter int COUNT_W = 16,
    parameter int TMO_W   = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               start_i,
    input logic               cycle_en_i,
    input logic               ready_o,
    input logic               timeout_o,
    input logic [COUNT_W-1:0] count_o,
    input logic               idle,
    input logic [TMO_W-1:0]   tmo_cnt,
    input logic [TMO_W-1:0]   tmo_thr
);
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!ready_o && !timeout_o && count_o == '0));

    a_r12_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ready_o && timeout_o));

    a_r10_timeout_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_o) |-> (count_o == '0));

    a_r2_ready_nonzero: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> (count_o != '0));

    a_r6_result_held: assert property (@(posedge clk) disable iff (rst)
        (ready_o && idle && !cycle_en_i && !(start_i && !$past(start_i)))
        |=> (ready_o && $stable(count_o)));

    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (idle && !cycle_en_i && !start_i) |=> idle);

    a_r10_tmo_bound: assert property (@(posedge clk) disable iff (rst)
        !idle |-> (tmo_cnt <= tmo_thr));
endmodule

bind slowcal_meter slowcal_meter_chk #(
    .COUNT_W (COUNT_W),
    .TMO_W   (TMO_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .cycle_en_i (cycle_en_i),
    .ready_o    (ready_o),
    .timeout_o  (timeout_o),
    .count_o    (count_o),
    .idle       (eng_idle),
    .tmo_cnt    (eng_tmo_cnt),
    .tmo_thr    (eng_tmo_thr)
);

// File: tb/slowcal_meter_tb_top.sv
`timescale 1ns/1ps
module slowcal_meter_tb_top;
    localparam int NUM_SRC = 4;
    localparam int LIMIT_W = 3;
    localparam int COUNT_W = 12;
    localparam int TMO_W   = 12;
    localparam int SEL_W   = 2;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NUM_SRC-1:0] slow = '0;
    logic [SEL_W-1:0]   sel = '0;
    logic [LIMIT_W-1:0] lim = 3'd2;
    logic               start = 1'b0;
    logic               cyc = 1'b1;
    logic [TMO_W-1:0]   thr = 12'd1000;
    logic               ready, tmo;
    logic [COUNT_W-1:0] count;

    int half [NUM_SRC] = '{1, 3, 5, 0};
    int hc   [NUM_SRC] = '{0, 0, 0, 0};
    int n_checks = 0;
    int n_err    = 0;
    int cyc_cnt  = 0;
    bit ended    = 1'b0;

    always #2 clk = ~clk;

    slowcal_meter #(
        .NUM_SRC (NUM_SRC),
        .LIMIT_W (LIMIT_W),
        .COUNT_W (COUNT_W),
        .TMO_W   (TMO_W)
    ) dut_i (
        .clk          (clk),
        .rst          (rst),
        .slow_clk_i   (slow),
        .sel_i        (sel),
        .limit_i      (lim),
        .start_i      (start),
        .cycle_en_i   (cyc),
        .tmo_thresh_i (thr),
        .ready_o      (ready),
        .timeout_o    (tmo),
        .count_o      (count)
    );

    // Slow sources: toggle every half[i] reference cycles, half 0 = stuck
    always @(posedge clk) begin
        for (int i = 0; i < NUM_SRC; i++) begin
            if (half[i] != 0) begin
                if (hc[i] + 1 >= half[i]) begin
                    slow[i] <= ~slow[i];
                    hc[i]   <= 0;
                end else begin
                    hc[i] <= hc[i] + 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150000 && !ended) begin
            ended = 1'b1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, 150000);
            summary();
        end
    end

    function automatic int exp_count(input int s, input int l);
        return ((l == 0) ? 1 : l) * 2 * half[s];
    endfunction

    task automatic kick(input int s, input int l, input int t);
        @(negedge clk);
        sel   = SEL_W'(s);
        lim   = LIMIT_W'(l);
        thr   = TMO_W'(t);
        start = 1'b0;
        @(negedge clk);
        start = 1'b1;
    endtask

    task automatic wait_end(output int n);
        n = 0;
        do begin
            @(posedge clk);
            #1;
            n++;
        end while (!(ready || tmo) && n < 3000);
    endtask

    task automatic idle_cycles(input int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    initial begin
        int n;
        int tlist [4] = '{0, 1, 5, 37};

        idle_cycles(4);
        chk(!ready && !tmo && count == 0, "R1 reset state", int'(count), 0);
        @(negedge clk);
        rst = 1'b0;
        #2.5;
        chk(!ready && !tmo && count == 0, "R1 first cycle after reset", int'(count), 0);

        // cycling mode from reset
        idle_cycles(200);
        chk(ready && !tmo && count == 4, "R7 cycling result", int'(count), 4);
        @(negedge clk);
        half[0] = 2;
        idle_cycles(200);
        chk(ready && count == 8, "R7 cycling tracks new period", int'(count), 8);

        // leave cycling mode
        @(negedge clk);
        cyc = 1'b0;
        idle_cycles(100);
        chk(ready && count == 8, "R8 running cycle completes", int'(count), 8);
        @(negedge clk);
        half[0] = 1;
        idle_cycles(100);
        chk(ready && count == 8, "R8 idle after cycling off", int'(count), 8);

        // one-off sweep over sources and every limit
        for (int s = 0; s < 3; s++) begin
            for (int l = 0; l < 8; l++) begin
                kick(s, l, 1000);
                wait_end(n);
                if (l == 0)
                    chk(ready && !tmo && count == exp_count(s, l), "R3 zero limit",
                        int'(count), exp_count(s, l));
                else
                    chk(ready && !tmo && count == exp_count(s, l), "R2 R4 R5 one-off count",
                        int'(count), exp_count(s, l));
            end
        end

        // held result, no retrigger with start held high
        kick(0, 3, 1000);
        wait_end(n);
        chk(ready && count == 6, "R5 one-off result", int'(count), 6);
        @(negedge clk);
        half[0] = 2;
        idle_cycles(100);
        chk(ready && count == 6, "R6 result held while idle", int'(count), 6);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        #1;
        chk(!ready && !tmo, "R6 new start clears ready", int'(ready), 0);
        wait_end(n);
        chk(ready && count == 12, "R5 retriggered result", int'(count), 12);

        // configuration changes mid-measurement
        kick(1, 3, 1000);
        repeat (3) @(negedge clk);
        sel = 2'd0;
        lim = 3'd1;
        thr = 12'd2;
        wait_end(n);
        chk(ready && !tmo && count == 18, "R9 captured configuration", int'(count), 18);

        // timeout on a stuck source, exact latency
        for (int k = 0; k < 4; k++) begin
            kick(3, 1, tlist[k]);
            wait_end(n);
            chk(tmo && !ready && count == 0, "R10 timeout flag and zero count", int'(count), 0);
            chk(n == tlist[k] + 2, "R10 timeout latency", n, tlist[k] + 2);
        end
        kick(2, 7, 30);
        wait_end(n);
        chk(tmo && !ready && n == 32, "R10 timeout on slow source", n, 32);
        chk(!(tmo && ready), "R12 flags exclusive", int'(ready), 0);

        // recovery after timeout
        kick(1, 2, 1000);
        wait_end(n);
        chk(ready && !tmo && count == 12, "R11 result after timeout", int'(count), 12);

        // cycling with repeated timeouts, then recovery
        @(negedge clk);
        sel = 2'd3;
        lim = 3'd1;
        thr = 12'd10;
        cyc = 1'b1;
        idle_cycles(60);
        chk(tmo && !ready && count == 0, "R10 cycling timeout", int'(count), 0);
        @(negedge clk);
        sel = 2'd0;
        thr = 12'd1000;
        idle_cycles(100);
        chk(ready && !tmo && count == 4, "R11 cycling recovery", int'(count), 4);
        @(negedge clk);
        cyc = 1'b0;
        idle_cycles(40);

        ended = 1'b1;
        summary();
    end
endmodule